// File: doc/BRIEF.md
# Flash Code Protection Access Gate

This block decides which ways into on-chip flash stay open once the device has booted. At boot, a 32-bit word read from a reserved flash location arrives with a load strobe. The block compares that word against three protection patterns and latches the resulting level. The level holds until the next reset.

From the latched level the block drives two enables. One allows the debug port. The other allows the hardware pin that forces the device into in-system programming (ISP). The block also judges every ISP command the command parser hands it. A command carries an operation, a target sector and an erase-everything flag, and the block answers with a registered allow or deny.

Requests from application code to program its own flash (IAP) are always granted, whatever the level. The flash array, the command parser and the debug logic sit outside this block.

Top module: `flash_lock_gate`

## Requirements
- R1: A loaded word equal to 32'h1A5C3E71 decodes as level 1, 32'h2B6D4F82 as level 2 and 32'h3C7E5093 as level 3. Any other word, including one that differs from a pattern in a single bit, decodes as level 0. The latched level is visible on `prot_level`.
- R2: After reset and before the first load, `prot_level` reads 3 and every ISP command is denied.
- R3: The first `prot_load` pulse after reset latches the decoded level. Later pulses have no effect until the next reset.
- R4: `dbg_en` is high only when the level is 0.
- R5: `isp_pin_en` is high at levels 0, 1 and 2, and low at level 3.
- R6: Operations are encoded on `cmd_op` as 0 read, 1 program, 2 erase and 3 run. At level 0 every command is allowed.
- R7: At level 1, read is denied. Program is allowed only to a sector other than 0. Erase is allowed only to a sector other than 0 with `cmd_erase_all` low. Run is allowed.
- R8: At level 2, read is denied and run is allowed. Erase is allowed only with `cmd_erase_all` high, whatever the sector. Program is denied until the erase-done flag is set.
- R9: At level 2, a pulse on `erase_fin` sets an erase-done flag that only reset clears. Once the flag is set, program is allowed to any sector.
- R10: At level 3, every ISP command is denied.
- R11: Each cycle with `iap_req` high is followed one cycle later by `iap_grant` high, at every level.
- R12: `resp_valid` and `cmd_allow` reflect the command presented in the previous cycle. Both are low in the cycle after one with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_word | input | PW | Protection word read from flash |
| prot_load | input | 1 | Strobe that latches the decoded level |
| erase_fin | input | 1 | Pulse marking completion of a whole-device erase |
| cmd_valid | input | 1 | ISP command present |
| cmd_op | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 run |
| cmd_sector | input | SECT_W | Target sector |
| cmd_erase_all | input | 1 | Erase covers the whole device |
| iap_req | input | 1 | In-application programming request |
| prot_level | output | 2 | Latched protection level |
| dbg_en | output | 1 | Debug port enable |
| isp_pin_en | output | 1 | ISP-entry pin override enable |
| resp_valid | output | 1 | Decision for previous cycle's command is valid |
| cmd_allow | output | 1 | Command allowed |
| iap_grant | output | 1 | IAP request granted |

## Verification
The assertions assume a well-formed stream of inputs. Commands last a single cycle. The level is loaded through one strobe pulse. `erase_fin` pulses only after the parser has run an allowed whole-device erase. The bench keeps to this stream. It drives every input on the falling clock edge and reads every decision at the next falling edge. It also resets the block before each level is loaded, so each sweep starts with the erase-done flag clear and can test the pattern once.

// File: rtl/flg_pkg.sv
package flg_pkg;
   typedef enum logic [1:0] {
      LVL_OPEN   = 2'd0,
      LVL_SHIELD = 2'd1,
      LVL_WIPE   = 2'd2,
      LVL_SEAL   = 2'd3
   } lvl_t;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_RUN   = 2'd3
   } op_t;

   localparam int NUM_LOCKED = 3;
endpackage

// File: rtl/flg_decode.sv
module flg_decode
   import flg_pkg::*;
#(
   parameter int                         PW   = 32,
   parameter logic [NUM_LOCKED*PW-1:0]   PATS = '0
) (
   input  logic [PW-1:0] word,
   output lvl_t          lvl
);
   logic [NUM_LOCKED-1:0] hit;

   if (PW < 8) begin : g_bad_width
      $error("flg_decode: PW too small for distinct patterns");
   end

   for (genvar i = 0; i < NUM_LOCKED; i++) begin : g_cmp
      assign hit[i] = (word == PATS[i*PW +: PW]);
      for (genvar j = i + 1; j < NUM_LOCKED; j++) begin : g_dist
         if (PATS[i*PW +: PW] == PATS[j*PW +: PW]) begin : g_dup
            $error("flg_decode: protection patterns must differ");
         end
      end
   end

   always_comb begin
      lvl = LVL_OPEN;
      for (int i = 0; i < NUM_LOCKED; i++) begin
         if (hit[i]) lvl = lvl_t'(2'(i + 1));
      end
   end

   always_comb begin
      assert ($countones(hit) <= 1) else $error("AST_ONE_HIT"); // R1
   end
endmodule

// File: rtl/flg_state.sv
module flg_state
   import flg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  lvl_t dec_lvl,
   input  logic erase_fin,
   output lvl_t lvl,
   output logic erased
);
   logic loaded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl    <= LVL_SEAL;
         loaded <= 1'b0;
         erased <= 1'b0;
      end else begin
         if (load && !loaded) begin
            lvl    <= dec_lvl;
            loaded <= 1'b1;
         end
         if (erase_fin && loaded && lvl == LVL_WIPE) erased <= 1'b1;
      end
   end

   AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> $stable(lvl)); // R3
   AST_ERASED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      erased |=> erased); // R9
   AST_PRELOAD_SEAL: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> lvl == LVL_SEAL); // R2
endmodule

// File: rtl/flg_judge.sv
module flg_judge
   import flg_pkg::*;
#(
   parameter int SECT_W    = 4,
   parameter int PROT_SECT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lvl_t              lvl,
   input  logic              erased,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [SECT_W-1:0] cmd_sector,
   input  logic              cmd_erase_all,
   input  logic              iap_req,
   output logic              dbg_en,
   output logic              isp_pin_en,
   output logic              resp_valid,
   output logic              allow,
   output logic              iap_grant
);
   localparam int NUM_SECT = 1 << SECT_W;
   localparam logic [SECT_W-1:0] PROT_IDX = SECT_W'(PROT_SECT);

   if (SECT_W < 1 || PROT_SECT < 0 || PROT_SECT >= NUM_SECT) begin : g_bad_sect
      $error("flg_judge: protected sector outside the sector range");
   end

   op_t  op;
   logic hits_prot;
   logic ok;

   assign op        = op_t'(cmd_op);
   assign hits_prot = (cmd_sector == PROT_IDX);

   always_comb begin
      ok = 1'b0;
      unique case (lvl)
         LVL_OPEN:   ok = 1'b1;
         LVL_SHIELD: begin
            unique case (op)
               OP_READ:  ok = 1'b0;
               OP_PROG:  ok = !hits_prot;
               OP_ERASE: ok = !hits_prot && !cmd_erase_all;
               OP_RUN:   ok = 1'b1;
            endcase
         end
         LVL_WIPE: begin
            unique case (op)
               OP_READ:  ok = 1'b0;
               OP_PROG:  ok = erased;
               OP_ERASE: ok = cmd_erase_all;
               OP_RUN:   ok = 1'b1;
            endcase
         end
         LVL_SEAL:   ok = 1'b0;
      endcase
   end

   assign dbg_en     = (lvl == LVL_OPEN);
   assign isp_pin_en = (lvl != LVL_SEAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         allow      <= 1'b0;
         iap_grant  <= 1'b0;
      end else begin
         resp_valid <= cmd_valid;
         allow      <= cmd_valid && ok;
         iap_grant  <= iap_req;
      end
   end

   AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid); // R12
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !allow && !resp_valid); // R12
   AST_SEAL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && lvl == LVL_SEAL |=> !allow); // R10
   AST_SECT0_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && lvl == LVL_SHIELD && hits_prot &&
      (op == OP_PROG || op == OP_ERASE) |=> !allow); // R7
   AST_WIPE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && lvl == LVL_WIPE && op == OP_PROG && !erased |=> !allow); // R8
   AST_OPEN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && lvl == LVL_OPEN |=> allow); // R6
   AST_IAP_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      iap_req |=> iap_grant); // R11
endmodule

// File: rtl/flash_lock_gate.sv
module flash_lock_gate
   import flg_pkg::*;
#(
   parameter int              PW        = 32,
   parameter int              SECT_W    = 4,
   parameter int              PROT_SECT = 0,
   parameter logic [PW-1:0]   PAT1      = 32'h1A5C3E71,
   parameter logic [PW-1:0]   PAT2      = 32'h2B6D4F82,
   parameter logic [PW-1:0]   PAT3      = 32'h3C7E5093
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     prot_word,
   input  logic              prot_load,
   input  logic              erase_fin,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [SECT_W-1:0] cmd_sector,
   input  logic              cmd_erase_all,
   input  logic              iap_req,
   output logic [1:0]        prot_level,
   output logic              dbg_en,
   output logic              isp_pin_en,
   output logic              resp_valid,
   output logic              cmd_allow,
   output logic              iap_grant
);
   lvl_t dec_lvl;
   lvl_t lvl;
   logic erased;

   flg_decode #(
      .PW   (PW),
      .PATS ({PAT3, PAT2, PAT1})
   ) u_decode (
      .word (prot_word),
      .lvl  (dec_lvl)
   );

   flg_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (prot_load),
      .dec_lvl   (dec_lvl),
      .erase_fin (erase_fin),
      .lvl       (lvl),
      .erased    (erased)
   );

   flg_judge #(
      .SECT_W    (SECT_W),
      .PROT_SECT (PROT_SECT)
   ) u_judge (
      .clk           (clk),
      .rst_n         (rst_n),
      .lvl           (lvl),
      .erased        (erased),
      .cmd_valid     (cmd_valid),
      .cmd_op        (cmd_op),
      .cmd_sector    (cmd_sector),
      .cmd_erase_all (cmd_erase_all),
      .iap_req       (iap_req),
      .dbg_en        (dbg_en),
      .isp_pin_en    (isp_pin_en),
      .resp_valid    (resp_valid),
      .allow         (cmd_allow),
      .iap_grant     (iap_grant)
   );

   assign prot_level = lvl;

   AST_DBG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lvl != LVL_OPEN |-> !dbg_en); // R4
   AST_PIN_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
      lvl == LVL_SEAL |-> !isp_pin_en); // R5
endmodule

// File: tb/flash_lock_gate_bench.sv
module flash_lock_gate_bench;
   localparam logic [31:0] P1 = 32'h1A5C3E71;
   localparam logic [31:0] P2 = 32'h2B6D4F82;
   localparam logic [31:0] P3 = 32'h3C7E5093;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] prot_word = '0;
   logic        prot_load = 1'b0;
   logic        erase_fin = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [3:0]  cmd_sector = '0;
   logic        cmd_erase_all = 1'b0;
   logic        iap_req = 1'b0;
   logic [1:0]  prot_level;
   logic        dbg_en, isp_pin_en, resp_valid, cmd_allow, iap_grant;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_lock_gate u_flash_lock_gate (
      .clk(clk), .rst_n(rst_n), .prot_word(prot_word), .prot_load(prot_load),
      .erase_fin(erase_fin), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sector(cmd_sector), .cmd_erase_all(cmd_erase_all), .iap_req(iap_req),
      .prot_level(prot_level), .dbg_en(dbg_en), .isp_pin_en(isp_pin_en),
      .resp_valid(resp_valid), .cmd_allow(cmd_allow), .iap_grant(iap_grant)
   );

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_ok(int lv, bit er, int op, int sec, bit all);
      case (lv)
         0: return 1'b1;
         1: case (op)
               0: return 1'b0;
               1: return sec != 0;
               2: return sec != 0 && !all;
               default: return 1'b1;
            endcase
         2: case (op)
               0: return 1'b0;
               1: return er;
               2: return all;
               default: return 1'b1;
            endcase
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0; prot_load = 1'b0; erase_fin = 1'b0; iap_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load(input logic [31:0] w);
      @(negedge clk);
      prot_word = w; prot_load = 1'b1;
      @(negedge clk);
      prot_load = 1'b0;
   endtask

   task automatic issue(input int op, input int sec, input bit all, output bit v, output bit a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sector = 4'(sec); cmd_erase_all = all;
      @(negedge clk);
      cmd_valid = 1'b0;
      v = resp_valid; a = cmd_allow;
   endtask

   task automatic sweep(input int lv, input bit er, input string req);
      bit v, a;
      for (int op = 0; op < 4; op++)
         for (int sec = 0; sec < 16; sec++)
            for (int all = 0; all < 2; all++) begin
               issue(op, sec, all[0], v, a);
               chk(int'(v), 1, "R12 resp_valid");
               chk(int'(a), int'(exp_ok(lv, er, op, sec, all[0])), req);
            end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit v, a;
      logic [31:0] words [4];
      string reqs [4];
      words[0] = 32'h12345678; words[1] = P1; words[2] = P2; words[3] = P3;
      reqs[0] = "R6 open"; reqs[1] = "R7 shield"; reqs[2] = "R8 wipe"; reqs[3] = "R10 seal";

      do_reset();
      @(negedge clk);
      chk(int'(prot_level), 3, "R2 preload level");
      chk(int'(dbg_en), 0, "R4 preload dbg");
      chk(int'(isp_pin_en), 0, "R5 preload pin");
      chk(int'(resp_valid), 0, "R12 idle resp");
      issue(3, 5, 1'b0, v, a);
      chk(int'(a), 0, "R2 preload deny");

      for (int lv = 0; lv < 4; lv++) begin
         do_reset();
         load(words[lv]);
         chk(int'(prot_level), lv, "R1 decode");
         chk(int'(dbg_en), int'(lv == 0), "R4 dbg_en");
         chk(int'(isp_pin_en), int'(lv != 3), "R5 isp_pin_en");
         sweep(lv, 1'b0, reqs[lv]);
         @(negedge clk);
         chk(int'(resp_valid), 0, "R12 no cmd resp");
         chk(int'(cmd_allow), 0, "R12 no cmd allow");
         iap_req = 1'b1;
         @(negedge clk);
         iap_req = 1'b0;
         chk(int'(iap_grant), 1, "R11 iap grant");
         if (lv == 2) begin
            @(negedge clk);
            erase_fin = 1'b1;
            @(negedge clk);
            erase_fin = 1'b0;
            sweep(2, 1'b1, "R9 after erase");
         end
         load(words[(lv + 1) % 4]);
         chk(int'(prot_level), lv, "R3 second load ignored");
         chk(int'(dbg_en), int'(lv == 0), "R3 dbg unchanged");
      end

      do_reset();
      load(P2 ^ 32'h0000_0100);
      chk(int'(prot_level), 0, "R1 near miss");
      do_reset();
      load(P1);
      @(negedge clk);
      erase_fin = 1'b1;
      @(negedge clk);
      erase_fin = 1'b0;
      issue(1, 0, 1'b0, v, a);
      chk(int'(a), 0, "R7 erase_fin no effect at level 1");
      do_reset();
      load(P2);
      issue(1, 7, 1'b0, v, a);
      chk(int'(a), 0, "R8 program before erase");
      do_reset();
      load(P2);
      issue(1, 7, 1'b0, v, a);
      chk(int'(a), 0, "R9 flag cleared by reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule